// File: doc/BRIEF.md
# Move Elimination Decision Unit

This block sits in the rename stage of an out-of-order core. It looks at one register-to-register move per clock. For each move it decides whether the move can be retired at rename by pointing the destination at the source's value, instead of allocating a new physical register for it. It answers in the same cycle with an accept or reject verdict. It also supplies the alias target to record and tells whether the move copies a value known to be zero. Next to the decision it keeps the alias table, a zero-register bitmap and a per-file count of eliminated moves. A cycle-start pulse clears those counts.

The register topology is computed from parameters, so no table has to be stored for it. There are 32 logical registers in groups of four. Lane 0 of a group is the wide register and lanes 1 to 3 are its sub-registers. A group belongs to register file (group mod 4). In even groups the sub-registers rename as the group's wide register. In odd groups every register renames as itself. The parameter `MOVE_OK` marks which wide registers accept elimination; by default only register 0 does. `FILE_QUOTA` holds a 3-bit per-cycle limit per file, with defaults 2, 0, 1 and 3 for files 0 to 3, where 0 means unlimited. `ZERO_ONLY` marks files that eliminate only moves of known-zero values; by default that is file 3. Ordinary (non-eliminated) writes come in on a separate write port and update the alias table and the zero bitmap.

The decision has six verdicts, coded on `mv_verdict`: ACCEPT=0, REJECT_CROSS_FILE=1, REJECT_PARTIAL=2, REJECT_QUOTA=3, REJECT_NOT_ZERO=4, IDLE=5. A valid move is tested against four rules in a fixed order, and the first rule that fails gives the verdict:
- the file match is tested first (failure gives REJECT_CROSS_FILE);
- then the partial-write rule (REJECT_PARTIAL);
- then the quota (REJECT_QUOTA);
- then zero-only mode (REJECT_NOT_ZERO).

A move that passes all four gets ACCEPT. A cycle with no move gives IDLE.

Top module: `mvelim_unit`

## Requirements
- R1: After reset, and in any cycle with `mv_valid` low, `mv_accept`, `mv_zero_read` and `mv_zero_write` are 0 and `mv_verdict` is 5. Reset empties the alias table and clears the zero bitmap and all quota counts.
- R2: A move whose source and destination lie in different files (file = (reg/4) mod 4) is rejected with verdict 1.
- R3: When the destination renames as a different register (a sub-lane of an even group), the move is rejected with verdict 2 unless `mv_clr_super` is 1 and that wide register's bit in `MOVE_OK` is set.
- R4: A file with a nonzero quota Q rejects with verdict 3 once Q moves have been accepted for it since the last cycle start. A quota of 0 never rejects.
- R5: `cycle_start` zeroes every file's count. A move in the same cycle as the pulse sees a count of 0 and is counted into the new period.
- R6: A file flagged in `ZERO_ONLY` rejects with verdict 4 unless the zero bitmap marks the source register.
- R7: `mv_alias_tgt` is the source's rename-as register or, when that register already holds an alias, the stored alias target, so chains stay one level deep.
- R8: On accept, the destination's rename-as register and its sub-registers record the alias target from the next cycle on, and the file's count rises by one.
- R9: On accept with a known-zero source, `mv_zero_read` and `mv_zero_write` are 1. The zero bits of the destination (of its rename-as register if `mv_clr_super`) and of its sub-registers take that value, and when `mv_clr_super` is 1 its super-register does too.
- R10: A write on the write port clears the alias of its rename-as register and that register's sub-registers, and also of its super-register when `wr_clr_super` is 1.
- R11: A write sets the zero bits to `wr_zero_idiom`. It covers the written register and its sub-registers, or, with `wr_clr_super`, its rename-as register, the sub-registers of that and its super-register.
- R12: Reject reasons take the priority given by the order of R2, R3, R4, R6. When a move and a write update the same table bit in one cycle, the write's value wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cycle_start | input | 1 | Start of a new quota period |
| mv_valid | input | 1 | A move is offered this cycle |
| mv_src | input | 5 | Move source register |
| mv_dst | input | 5 | Move destination register |
| mv_clr_super | input | 1 | Move write clears its super-register |
| wr_valid | input | 1 | An ordinary write is renamed this cycle |
| wr_reg | input | 5 | Written register |
| wr_zero_idiom | input | 1 | The write produces zero |
| wr_clr_super | input | 1 | The write clears its super-register |
| mv_accept | output | 1 | Move eliminated |
| mv_verdict | output | 3 | Verdict code (0 to 5) |
| mv_alias_tgt | output | 5 | Register the destination now aliases |
| mv_zero_read | output | 1 | Source read is a known zero |
| mv_zero_write | output | 1 | Destination write is a zero write |

## Verification
The verdict, alias target and zero flags depend combinationally on the move inputs and the current tables. They are due in the same cycle the move is driven, and the bench samples them 2 ns after driving, with the clock still low. Table and count updates land on the next rising edge and first affect the verdicts of the following cycle. The bench's reference model applies them only after that edge, move first and write second. Directed sequences cover chains, quotas across periods and zero-only files. A seeded random mix then drives the same model.

// File: rtl/mvelim_pkg.sv
package mvelim_pkg;

    typedef enum logic [2:0] {
        VD_ACCEPT        = 3'd0,
        VD_REJECT_XFILE  = 3'd1,
        VD_REJECT_PART   = 3'd2,
        VD_REJECT_QUOTA  = 3'd3,
        VD_REJECT_NZERO  = 3'd4,
        VD_IDLE          = 3'd5
    } verdict_e;

endpackage

// File: rtl/mvelim_topo.sv
module mvelim_topo #(
    parameter int NREG  = 32,
    parameter int GROUP = 4,
    parameter int NFILE = 4,
    parameter int IDW   = $clog2(NREG),
    parameter int FW    = $clog2(NFILE)
) (
    input  logic [IDW-1:0]  reg_id,
    output logic [FW-1:0]   file_idx,
    output logic [IDW-1:0]  ren_id,
    output logic [NREG-1:0] sub_mask,
    output logic [NREG-1:0] ren_sub_mask,
    output logic [NREG-1:0] ren_super_mask
);

    function automatic logic [NREG-1:0] subs_of(int x);
        logic [NREG-1:0] m;
        m = '0;
        if ((x % GROUP) == 0) begin
            for (int k = 1; k < GROUP; k++) m[x + k] = 1'b1;
        end
        return m;
    endfunction

    function automatic logic [NREG-1:0] supers_of(int x);
        logic [NREG-1:0] m;
        m = '0;
        if ((x % GROUP) != 0) m[x - (x % GROUP)] = 1'b1;
        return m;
    endfunction

    always_comb begin
        int r;
        int rn;
        r  = int'(reg_id);
        rn = (((r / GROUP) % 2) == 0) ? (r - (r % GROUP)) : r;
        file_idx       = FW'((r / GROUP) % NFILE);
        ren_id         = IDW'(rn);
        sub_mask       = subs_of(r);
        ren_sub_mask   = subs_of(rn);
        ren_super_mask = supers_of(rn);
    end

endmodule

// File: rtl/mvelim_quota.sv
module mvelim_quota #(
    parameter int                    NFILE      = 4,
    parameter int                    QW         = 3,
    parameter logic [NFILE*QW-1:0]   FILE_QUOTA = '0,
    parameter int                    FW         = $clog2(NFILE)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cycle_start,
    input  logic [FW-1:0] file_sel,
    input  logic          bump,
    output logic          quota_hit
);

    logic [NFILE-1:0] hit_vec;

    generate
        for (genvar f = 0; f < NFILE; f++) begin : g_file
            localparam logic [QW-1:0] LIM = FILE_QUOTA[f*QW +: QW];
            logic [QW-1:0] cnt;
            logic [QW-1:0] eff;
            logic          inc;

            assign inc        = bump && (file_sel == FW'(f));
            assign eff        = cycle_start ? '0 : cnt;
            assign hit_vec[f] = (LIM != '0) && (eff >= LIM);

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cnt <= '0;
                end else if (inc && (eff != '1)) begin
                    cnt <= eff + 1'b1;
                end else begin
                    cnt <= eff;
                end
            end
        end
    endgenerate

    assign quota_hit = hit_vec[file_sel];

endmodule

// File: rtl/mvelim_tables.sv
module mvelim_tables #(
    parameter int NREG = 32,
    parameter int IDW  = $clog2(NREG)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [NREG-1:0] mv_alias_set,
    input  logic [IDW-1:0]  mv_tgt,
    input  logic [NREG-1:0] mv_zero_upd,
    input  logic            mv_zero_val,
    input  logic [NREG-1:0] wr_alias_clr,
    input  logic [NREG-1:0] wr_zero_upd,
    input  logic            wr_zero_val,
    input  logic [IDW-1:0]  look_reg,
    output logic            look_valid,
    output logic [IDW-1:0]  look_id,
    input  logic [IDW-1:0]  zq_reg,
    output logic            zq_bit
);

    logic [NREG-1:0] alias_v;
    logic [NREG-1:0] zero_map;
    logic [IDW-1:0]  alias_id [NREG];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            alias_v  <= '0;
            zero_map <= '0;
            for (int r = 0; r < NREG; r++) alias_id[r] <= '0;
        end else begin
            for (int r = 0; r < NREG; r++) begin
                if (wr_alias_clr[r]) begin
                    alias_v[r] <= 1'b0;
                end else if (mv_alias_set[r]) begin
                    alias_v[r] <= 1'b1;
                end
                if (mv_alias_set[r]) alias_id[r] <= mv_tgt;
                if (wr_zero_upd[r]) begin
                    zero_map[r] <= wr_zero_val;
                end else if (mv_zero_upd[r]) begin
                    zero_map[r] <= mv_zero_val;
                end
            end
        end
    end

    assign look_valid = alias_v[look_reg];
    assign look_id    = alias_id[look_reg];
    assign zq_bit     = zero_map[zq_reg];

endmodule

// File: rtl/mvelim_unit.sv
module mvelim_unit
    import mvelim_pkg::*;
#(
    parameter int                  NREG       = 32,
    parameter int                  GROUP      = 4,
    parameter int                  NFILE      = 4,
    parameter int                  QW         = 3,
    parameter logic [NFILE*QW-1:0] FILE_QUOTA = {3'd3, 3'd1, 3'd0, 3'd2},
    parameter logic [NFILE-1:0]    ZERO_ONLY  = 4'b1000,
    parameter logic [NREG-1:0]     MOVE_OK    = 32'h0000_0001
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cycle_start,
    input  logic                    mv_valid,
    input  logic [$clog2(NREG)-1:0] mv_src,
    input  logic [$clog2(NREG)-1:0] mv_dst,
    input  logic                    mv_clr_super,
    input  logic                    wr_valid,
    input  logic [$clog2(NREG)-1:0] wr_reg,
    input  logic                    wr_zero_idiom,
    input  logic                    wr_clr_super,
    output logic                    mv_accept,
    output logic [2:0]              mv_verdict,
    output logic [$clog2(NREG)-1:0] mv_alias_tgt,
    output logic                    mv_zero_read,
    output logic                    mv_zero_write
);

    localparam int IDW = $clog2(NREG);
    localparam int FW  = $clog2(NFILE);

    function automatic logic [NREG-1:0] onehot(logic [IDW-1:0] id);
        return {{(NREG-1){1'b0}}, 1'b1} << id;
    endfunction

    // topology taps
    logic [FW-1:0]   src_file, dst_file, wr_file;
    logic [IDW-1:0]  src_ren, dst_ren, wr_ren;
    logic [NREG-1:0] src_sub, src_ren_sub, src_ren_super;
    logic [NREG-1:0] dst_sub, dst_ren_sub, dst_ren_super;
    logic [NREG-1:0] wr_sub, wr_ren_sub, wr_ren_super;
    logic            unused_taps;

    mvelim_topo #(.NREG(NREG), .GROUP(GROUP), .NFILE(NFILE)) u_src_map (
        .reg_id(mv_src), .file_idx(src_file), .ren_id(src_ren),
        .sub_mask(src_sub), .ren_sub_mask(src_ren_sub), .ren_super_mask(src_ren_super)
    );

    mvelim_topo #(.NREG(NREG), .GROUP(GROUP), .NFILE(NFILE)) u_dst_map (
        .reg_id(mv_dst), .file_idx(dst_file), .ren_id(dst_ren),
        .sub_mask(dst_sub), .ren_sub_mask(dst_ren_sub), .ren_super_mask(dst_ren_super)
    );

    mvelim_topo #(.NREG(NREG), .GROUP(GROUP), .NFILE(NFILE)) u_wr_map (
        .reg_id(wr_reg), .file_idx(wr_file), .ren_id(wr_ren),
        .sub_mask(wr_sub), .ren_sub_mask(wr_ren_sub), .ren_super_mask(wr_ren_super)
    );

    assign unused_taps = ^{src_sub, src_ren_sub, src_ren_super, wr_file};

    // table and quota state
    logic            look_valid;
    logic [IDW-1:0]  look_id;
    logic            src_zero;
    logic            quota_hit;
    logic [NREG-1:0] mv_alias_set, mv_zero_upd, wr_alias_clr, wr_zero_upd;
    verdict_e        verdict;

    mvelim_tables #(.NREG(NREG)) u_tables (
        .clk(clk), .rst_n(rst_n),
        .mv_alias_set(mv_alias_set), .mv_tgt(mv_alias_tgt),
        .mv_zero_upd(mv_zero_upd), .mv_zero_val(mv_zero_write),
        .wr_alias_clr(wr_alias_clr), .wr_zero_upd(wr_zero_upd),
        .wr_zero_val(wr_zero_idiom),
        .look_reg(src_ren), .look_valid(look_valid), .look_id(look_id),
        .zq_reg(mv_src), .zq_bit(src_zero)
    );

    mvelim_quota #(.NFILE(NFILE), .QW(QW), .FILE_QUOTA(FILE_QUOTA)) u_quota (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .file_sel(src_file), .bump(mv_accept), .quota_hit(quota_hit)
    );

    // verdict selection: first failing rule wins
    always_comb begin
        if (!mv_valid) begin
            verdict = VD_IDLE;
        end else if (src_file != dst_file) begin
            verdict = VD_REJECT_XFILE;
        end else if ((dst_ren != mv_dst) && !(MOVE_OK[dst_ren] && mv_clr_super)) begin
            verdict = VD_REJECT_PART;
        end else if (quota_hit) begin
            verdict = VD_REJECT_QUOTA;
        end else if (ZERO_ONLY[src_file] && !src_zero) begin
            verdict = VD_REJECT_NZERO;
        end else begin
            verdict = VD_ACCEPT;
        end
    end

    // outputs per verdict
    always_comb begin
        mv_accept     = 1'b0;
        mv_zero_read  = 1'b0;
        mv_zero_write = 1'b0;
        mv_alias_tgt  = look_valid ? look_id : src_ren;
        unique case (verdict)
            VD_ACCEPT: begin
                mv_accept     = 1'b1;
                mv_zero_read  = src_zero;
                mv_zero_write = src_zero;
            end
            VD_REJECT_XFILE, VD_REJECT_PART, VD_REJECT_QUOTA,
            VD_REJECT_NZERO, VD_IDLE: begin
                mv_accept = 1'b0;
            end
            default: begin
                mv_accept = 1'b0;
            end
        endcase
    end

    assign mv_verdict = verdict;

    // update masks applied at the next edge
    always_comb begin
        mv_alias_set = '0;
        mv_zero_upd  = '0;
        wr_alias_clr = '0;
        wr_zero_upd  = '0;
        if (mv_accept) begin
            mv_alias_set = onehot(dst_ren) | dst_ren_sub;
            mv_zero_upd  = mv_clr_super ? (onehot(dst_ren) | dst_ren_sub | dst_ren_super)
                                        : (onehot(mv_dst) | dst_sub);
        end
        if (wr_valid) begin
            wr_alias_clr = onehot(wr_ren) | wr_ren_sub | (wr_clr_super ? wr_ren_super : '0);
            wr_zero_upd  = wr_clr_super ? (onehot(wr_ren) | wr_ren_sub | wr_ren_super)
                                        : (onehot(wr_reg) | wr_sub);
        end
    end

endmodule

// File: rtl/mvelim_unit_chk.sv
module mvelim_unit_chk #(
    parameter int                  NREG       = 32,
    parameter int                  GROUP      = 4,
    parameter int                  NFILE      = 4,
    parameter int                  QW         = 3,
    parameter logic [NFILE*QW-1:0] FILE_QUOTA = '0,
    parameter logic [NFILE-1:0]    ZERO_ONLY  = '0,
    parameter logic [NREG-1:0]     MOVE_OK    = '0
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    cycle_start,
    input logic                    mv_valid,
    input logic [$clog2(NREG)-1:0] mv_src,
    input logic [$clog2(NREG)-1:0] mv_dst,
    input logic                    mv_clr_super,
    input logic                    mv_accept,
    input logic [2:0]              mv_verdict,
    input logic [$clog2(NREG)-1:0] mv_alias_tgt,
    input logic                    mv_zero_read,
    input logic                    mv_zero_write
);

    function automatic int cfile(int r);
        return (r / GROUP) % NFILE;
    endfunction

    function automatic int cren(int r);
        return (((r / GROUP) % 2) == 0) ? (r - (r % GROUP)) : r;
    endfunction

    logic [QW-1:0] seen [NFILE];
    logic [QW-1:0] chk_eff, chk_lim;
    int            sf;

    always_comb begin
        sf      = cfile(int'(mv_src));
        chk_eff = cycle_start ? '0 : seen[sf];
        chk_lim = FILE_QUOTA[sf*QW +: QW];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int f = 0; f < NFILE; f++) seen[f] <= '0;
        end else begin
            for (int f = 0; f < NFILE; f++) begin
                if (mv_accept && (f == sf) && ((cycle_start ? '0 : seen[f]) != '1)) begin
                    seen[f] <= (cycle_start ? '0 : seen[f]) + 1'b1;
                end else begin
                    seen[f] <= cycle_start ? '0 : seen[f];
                end
            end
        end
    end

    assert_idle_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !mv_valid |-> (!mv_accept && mv_verdict == 3'd5 && !mv_zero_write));

    assert_cross_file_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_valid && cfile(int'(mv_src)) != cfile(int'(mv_dst))) |-> !mv_accept);

    assert_partial_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_accept && cren(int'(mv_dst)) != int'(mv_dst))
            |-> (mv_clr_super && MOVE_OK[cren(int'(mv_dst))]));

    assert_quota_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_accept && chk_lim != '0) |-> (chk_eff < chk_lim));

    assert_zero_only_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_accept && ZERO_ONLY[cfile(int'(mv_src))]) |-> mv_zero_read);

    assert_target_R7: assert property (@(posedge clk) disable iff (!rst_n)
        mv_accept |-> (cren(int'(mv_alias_tgt)) == int'(mv_alias_tgt)
                       && cfile(int'(mv_alias_tgt)) == cfile(int'(mv_src))));

    assert_zero_flags_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mv_zero_write || mv_zero_read) |-> (mv_accept && mv_zero_read == mv_zero_write));

endmodule

bind mvelim_unit mvelim_unit_chk #(
    .NREG(NREG), .GROUP(GROUP), .NFILE(NFILE), .QW(QW),
    .FILE_QUOTA(FILE_QUOTA), .ZERO_ONLY(ZERO_ONLY), .MOVE_OK(MOVE_OK)
) chk_i (
    .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
    .mv_valid(mv_valid), .mv_src(mv_src), .mv_dst(mv_dst),
    .mv_clr_super(mv_clr_super), .mv_accept(mv_accept),
    .mv_verdict(mv_verdict), .mv_alias_tgt(mv_alias_tgt),
    .mv_zero_read(mv_zero_read), .mv_zero_write(mv_zero_write)
);

// File: tb/mvelim_unit_tb_top.sv
module mvelim_unit_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cycle_start = 1'b0, mv_valid = 1'b0, mv_clr_super = 1'b0;
    logic [4:0] mv_src = '0, mv_dst = '0, wr_reg = '0;
    logic       wr_valid = 1'b0, wr_zero_idiom = 1'b0, wr_clr_super = 1'b0;
    logic       mv_accept, mv_zero_read, mv_zero_write;
    logic [2:0] mv_verdict;
    logic [4:0] mv_alias_tgt;

    always #4 clk = ~clk;

    mvelim_unit dut_i (
        .clk(clk), .rst_n(rst_n), .cycle_start(cycle_start),
        .mv_valid(mv_valid), .mv_src(mv_src), .mv_dst(mv_dst),
        .mv_clr_super(mv_clr_super), .wr_valid(wr_valid), .wr_reg(wr_reg),
        .wr_zero_idiom(wr_zero_idiom), .wr_clr_super(wr_clr_super),
        .mv_accept(mv_accept), .mv_verdict(mv_verdict),
        .mv_alias_tgt(mv_alias_tgt), .mv_zero_read(mv_zero_read),
        .mv_zero_write(mv_zero_write)
    );

    int total = 0;
    int bad = 0;
    bit finished = 0;

    // reference model state
    bit av [32];
    int at [32];
    bit zm [32];
    int qc [4];
    int lim [4] = '{2, 0, 1, 3};

    function automatic int bfile(int r);
        return (r / 4) % 4;
    endfunction

    function automatic int bren(int r);
        if (((r / 4) % 2) == 0) return r - (r % 4);
        return r;
    endfunction

    function automatic bit inset(int k, int x, bit with_super);
        if (k == x) return 1;
        if ((x % 4) == 0 && (k / 4) == (x / 4)) return 1;
        if (with_super && (x % 4) != 0 && k == x - (x % 4)) return 1;
        return 0;
    endfunction

    task automatic step(input bit cs, input bit mvv, input int s, input int d, input bit c,
                        input bit wv, input int w, input bit wz, input bit wc,
                        input string tag);
        int  f, eff, ev, t, a, z, r;
        bit  eacc, ezr;
        f   = bfile(s);
        eff = cs ? 0 : qc[f];
        if (!mvv) ev = 5;
        else if (bfile(s) != bfile(d)) ev = 1;
        else if (bren(d) != d && !(bren(d) == 0 && c)) ev = 2;
        else if (lim[f] != 0 && eff >= lim[f]) ev = 3;
        else if (f == 3 && !zm[s]) ev = 4;
        else ev = 0;
        t    = av[bren(s)] ? at[bren(s)] : bren(s);
        eacc = (ev == 0);
        ezr  = eacc && zm[s];

        cycle_start = cs; mv_valid = mvv; mv_src = 5'(s); mv_dst = 5'(d);
        mv_clr_super = c; wr_valid = wv; wr_reg = 5'(w);
        wr_zero_idiom = wz; wr_clr_super = wc;
        #2;
        total++;
        if (int'(mv_verdict) != ev || mv_accept != eacc || mv_zero_read != ezr ||
            mv_zero_write != ezr || (eacc && int'(mv_alias_tgt) != t)) begin
            bad++;
            $display("FAIL %s: verdict=%0d acc=%0b tgt=%0d zr=%0b zw=%0b expected verdict=%0d acc=%0b tgt=%0d zr=%0b zw=%0b",
                     tag, mv_verdict, mv_accept, mv_alias_tgt, mv_zero_read, mv_zero_write,
                     ev, eacc, t, ezr, ezr);
        end
        @(posedge clk);
        if (cs) for (int i = 0; i < 4; i++) qc[i] = 0;
        if (eacc) begin
            if (qc[f] < 7) qc[f]++;
            a = bren(d);
            for (int k = 0; k < 32; k++) if (inset(k, a, 0)) begin av[k] = 1; at[k] = t; end
            z = c ? a : d;
            for (int k = 0; k < 32; k++) if (inset(k, z, c)) zm[k] = ezr;
        end
        if (wv) begin
            r = bren(w);
            for (int k = 0; k < 32; k++) if (inset(k, r, wc)) av[k] = 0;
            z = wc ? r : w;
            for (int k = 0; k < 32; k++) if (inset(k, z, wc)) zm[k] = wz;
        end
        @(negedge clk);
    endtask

    initial begin
        #(8 * 200000);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog R1: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 32; i++) begin av[i] = 0; at[i] = 0; zm[i] = 0; end
        for (int i = 0; i < 4; i++) qc[i] = 0;
        repeat (3) @(negedge clk);
        total++;
        if (mv_accept !== 1'b0 || mv_verdict !== 3'd5) begin
            bad++;
            $display("FAIL R1 reset: acc=%0b verdict=%0d expected acc=0 verdict=5", mv_accept, mv_verdict);
        end
        rst_n = 1'b1;
        @(negedge clk);

        step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R1 idle");
        step(1, 1, 0, 4, 0, 0, 0, 0, 0, "R2 cross file");
        step(1, 1, 0, 16, 0, 0, 0, 0, 0, "R8 accept same file");
        step(1, 1, 16, 2, 0, 0, 0, 0, 0, "R3 partial without clear");
        step(1, 1, 16, 2, 1, 0, 0, 0, 0, "R7 chain collapse via clearing write");
        step(1, 1, 8, 9, 1, 0, 0, 0, 0, "R3 wide register forbids elimination");
        step(1, 1, 4, 9, 0, 0, 0, 0, 0, "R12 cross file outranks partial");
        step(1, 1, 8, 24, 0, 0, 0, 0, 0, "R4 first move in quota");
        step(0, 1, 24, 8, 0, 0, 0, 0, 0, "R4 quota reached");
        step(0, 1, 8, 24, 0, 0, 0, 0, 0, "R4 quota still reached");
        step(1, 1, 24, 8, 0, 0, 0, 0, 0, "R5 cycle start frees quota");
        step(1, 1, 4, 20, 0, 0, 0, 0, 0, "R4 unlimited file a");
        step(0, 1, 20, 5, 0, 0, 0, 0, 0, "R4 unlimited file b");
        step(0, 1, 5, 21, 0, 0, 0, 0, 0, "R4 unlimited file c");
        step(1, 1, 12, 28, 0, 0, 0, 0, 0, "R6 zero-only rejects");
        step(1, 0, 0, 0, 0, 1, 12, 1, 0, "R11 zero idiom write");
        step(1, 1, 12, 28, 0, 0, 0, 0, 0, "R9 zero move accepted");
        step(1, 1, 28, 13, 0, 0, 0, 0, 0, "R9 zero propagates");
        step(1, 0, 0, 0, 0, 1, 28, 0, 0, "R11 nonzero write");
        step(1, 1, 28, 13, 0, 0, 0, 0, 0, "R11 zero bit cleared");
        step(1, 0, 0, 0, 0, 1, 16, 0, 0, "R10 write on aliased register");
        step(1, 1, 16, 0, 0, 0, 0, 0, 0, "R10 alias cleared");
        step(1, 1, 0, 2, 1, 1, 2, 0, 1, "R12 move and write same cycle");
        step(1, 1, 0, 16, 0, 0, 0, 0, 0, "R12 write wins");
        step(1, 0, 0, 0, 0, 1, 13, 1, 1, "R11 clearing write hits super");
        step(1, 1, 12, 28, 0, 0, 0, 0, 0, "R11 super marked zero");

        for (int i = 0; i < 400; i++) begin
            int s  = int'($urandom % 32);
            int d  = int'($urandom % 32);
            bit cs = ($urandom % 3) == 0;
            bit mv = ($urandom % 8) != 0;
            bit c  = $urandom % 2;
            bit wv = $urandom % 2;
            int w  = int'($urandom % 32);
            bit wz = $urandom % 2;
            bit wc = $urandom % 2;
            if ($urandom % 2) d = (int'($urandom % 2) * 4 + bfile(s)) * 4 + int'($urandom % 4);
            step(cs, mv, s, d, c, wv, w, wz, wc, "R12 random mix");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule